// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of sixteen general-purpose pins with a small 16-bit register interface. Software sets the value each pin drives, whether its driver is enabled, and whether the pin is handed to an alternate peripheral. It can also read the current pin levels. Each register has one bit per pin.

Each pin can also act as an interrupt source. A pin can be set to edge mode, where it catches rising or falling transitions, or to level mode, where it catches a high or low level. Detected events are collected in a sticky status register. A status bit stays set until software writes a zero to that bit. The single `irq_pending` output goes high whenever some status bit is set and the mask does not block that pin. An upstream interrupt aggregator collects this line.

Detection of both edges is done in software. After each event, the handler inverts that pin's edge-polarity bit so that the opposite transition is caught next.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the output, direction, alternate, trigger, polarity, level and status registers read 0. The mask register reads 0xFFFF and `irq_pending` is low. No status bit sets during the first three cycles after reset is released.
- R2: Register offsets:
  - 0 is output data, which drives `pin_out`.
  - 1 is direction, which drives `pin_oe` (1 = output).
  - 2 is alternate select, which drives `pin_alt`.
  Each of these reads back the value written.
- R3: Offset 3 reads the pin levels. A change on `pin_in` appears there after two rising clock edges.
- R4: A pin with trigger bit 1 (offset 5) and polarity bit 1 (offset 6) sets its status bit (offset 8) on a rising input transition. The bit is visible three clock edges after the change. A falling transition on that pin sets nothing.
- R5: A pin with trigger bit 1 and polarity bit 0 sets its status bit on a falling transition only.
- R6: A pin with trigger bit 0 is level-triggered. The active level is high when its level bit (offset 7) is 1 and low when it is 0. Its status bit is set again on every cycle while the pin stays at the active level, even right after a clear.
- R7: A write to the status register clears the bits written as 0 and keeps the bits written as 1. A new event in the same cycle wins over the clear.
- R8: `irq_pending` is high exactly when some status bit is set and its mask bit (offset 4) is 0. A masked pin still latches its status bit.
- R9: Writes to offset 3 are ignored. Reads of unmapped offsets (9 to 15) return 0.
- R10: Inverting a pin's polarity bit after an event makes the opposite transition set the status bit. This gives detection of both edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Driver enables |
| pin_alt | output | 16 | Alternate-function selects |
| irq_pending | output | 1 | Unmasked event pending |

## Verification
- Register writes take effect at the rising edge where `reg_wr` is high, and reads are combinational. The bench therefore reads back in the low phase right after the write edge.
- A pin change driven in a low phase shows up in the pin-level read after exactly two rising edges. It shows up in the status register and `irq_pending` after exactly three.
- The edge tests sample one edge early and expect no status bit yet, then sample at the due edge and expect the bit. This pins down the latency in both directions.
- The clear-versus-event race is built by issuing the clear so that it commits on the very edge that latches the new event.

// File: rtl/gpio_bank_pkg.sv
// Shared constants for the GPIO bank: register offsets.
// Assumes a 4-bit offset space; offsets 9..15 are unmapped.
package gpio_bank_pkg;
    typedef enum logic [3:0] {
        OFF_OUT   = 4'd0,
        OFF_DIR   = 4'd1,
        OFF_ALT   = 4'd2,
        OFF_PINS  = 4'd3,
        OFF_MASK  = 4'd4,
        OFF_TRIG  = 4'd5,
        OFF_RISE  = 4'd6,
        OFF_HIGH  = 4'd7,
        OFF_STAT  = 4'd8
    } reg_off_e;

    localparam int MASK_RESET_ALL = 1;
endpackage

// File: rtl/gpio_bank_sync.sv
// Multi-flop synchroniser for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is provided.
module gpio_bank_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [STAGES-1:0][W-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // shift toward the output
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_detect.sv
// Per-pin edge/level event detector working on synchronised samples.
// Assumes smp is already synchronous. Events are suppressed until the
// synchroniser and previous-sample flop have been refilled after reset.
module gpio_bank_detect #(
    parameter int W        = 16,
    parameter int ARM_LEN  = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    input  logic [W-1:0] trig_edge,
    input  logic [W-1:0] rise_sel,
    input  logic [W-1:0] high_sel,
    output logic [W-1:0] evt
);
    logic [W-1:0]       prev;
    logic [ARM_LEN-1:0] arm;
    logic               armed;

    // remember last synchronised sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= smp;
    end

    // warm-up shift register gating events after reset
    always_ff @(posedge clk) begin
        if (!rst_n) arm <= '0;
        else        arm <= {arm[ARM_LEN-2:0], 1'b1};
    end

    assign armed = arm[ARM_LEN-1];

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            logic rise_hit, fall_hit, lvl_hit;
            // classify this pin's sample against its configuration
            always_comb begin
                rise_hit = smp[i] & ~prev[i];
                fall_hit = ~smp[i] & prev[i];
                lvl_hit  = (smp[i] == high_sel[i]);
                if (!armed)            evt[i] = 1'b0;
                else if (trig_edge[i]) evt[i] = rise_sel[i] ? rise_hit : fall_hit;
                else                   evt[i] = lvl_hit;
            end

            AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
                (trig_edge[i] && evt[i]) |-> (smp[i] != prev[i])); // R4
        end
    endgenerate

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (evt == '0)); // R1
endmodule

// File: rtl/gpio_bank_regs.sv
// Register file and sticky status latch for the GPIO bank.
// Assumes one write per cycle; reads are combinational on the offset.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int W      = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pins,
    input  logic [W-1:0]      evt,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      alt_q,
    output logic [W-1:0]      mask_q,
    output logic [W-1:0]      trig_q,
    output logic [W-1:0]      rise_q,
    output logic [W-1:0]      high_q,
    output logic [W-1:0]      stat_q
);
    logic hit_out, hit_dir, hit_alt, hit_mask, hit_trig, hit_rise, hit_high, hit_stat;

    // decode write strobes per register
    always_comb begin
        hit_out  = wr && (addr == ADDR_W'(OFF_OUT));
        hit_dir  = wr && (addr == ADDR_W'(OFF_DIR));
        hit_alt  = wr && (addr == ADDR_W'(OFF_ALT));
        hit_mask = wr && (addr == ADDR_W'(OFF_MASK));
        hit_trig = wr && (addr == ADDR_W'(OFF_TRIG));
        hit_rise = wr && (addr == ADDR_W'(OFF_RISE));
        hit_high = wr && (addr == ADDR_W'(OFF_HIGH));
        hit_stat = wr && (addr == ADDR_W'(OFF_STAT));
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            alt_q  <= '0;
            mask_q <= (MASK_RESET_ALL != 0) ? '1 : '0;
            trig_q <= '0;
            rise_q <= '0;
            high_q <= '0;
        end else begin
            if (hit_out)  out_q  <= wdata;
            if (hit_dir)  dir_q  <= wdata;
            if (hit_alt)  alt_q  <= wdata;
            if (hit_mask) mask_q <= wdata;
            if (hit_trig) trig_q <= wdata;
            if (hit_rise) rise_q <= wdata;
            if (hit_high) high_q <= wdata;
        end
    end

    // sticky status: zero-write clears, new events win
    always_ff @(posedge clk) begin
        if (!rst_n)        stat_q <= '0;
        else if (hit_stat) stat_q <= (stat_q & wdata) | evt;
        else               stat_q <= stat_q | evt;
    end

    // read multiplexer
    always_comb begin
        unique case (addr)
            ADDR_W'(OFF_OUT):  rdata = out_q;
            ADDR_W'(OFF_DIR):  rdata = dir_q;
            ADDR_W'(OFF_ALT):  rdata = alt_q;
            ADDR_W'(OFF_PINS): rdata = pins;
            ADDR_W'(OFF_MASK): rdata = mask_q;
            ADDR_W'(OFF_TRIG): rdata = trig_q;
            ADDR_W'(OFF_RISE): rdata = rise_q;
            ADDR_W'(OFF_HIGH): rdata = high_q;
            ADDR_W'(OFF_STAT): rdata = stat_q;
            default:           rdata = '0;
        endcase
    end

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R7
    AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt))); // R6
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_stat && wdata == '0 && evt == '0) |=> (stat_q == '0)); // R7
endmodule

// File: rtl/gpio_irq_bank.sv
// Top of one GPIO bank: synchroniser, event detector, register file
// and the pending-interrupt reduction.
// Assumes pin_in is asynchronous; pad drivers live outside this block.
module gpio_irq_bank #(
    parameter int PINS       = 16,
    parameter int ADDR_W     = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [PINS-1:0]   reg_wdata,
    output logic [PINS-1:0]   reg_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_alt,
    output logic              irq_pending
);
    localparam int ARM_LEN = SYNC_DEPTH + 1;

    logic [PINS-1:0] smp, evt, mask_q, trig_q, rise_q, high_q, stat_q;

    gpio_bank_sync #(.W(PINS), .STAGES(SYNC_DEPTH)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(smp)
    );

    gpio_bank_detect #(.W(PINS), .ARM_LEN(ARM_LEN)) i_detect (
        .clk(clk), .rst_n(rst_n), .smp(smp), .trig_edge(trig_q),
        .rise_sel(rise_q), .high_sel(high_q), .evt(evt)
    );

    gpio_bank_regs #(.W(PINS), .ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .pins(smp), .evt(evt), .rdata(reg_rdata),
        .out_q(pin_out), .dir_q(pin_oe), .alt_q(pin_alt), .mask_q(mask_q),
        .trig_q(trig_q), .rise_q(rise_q), .high_q(high_q), .stat_q(stat_q)
    );

    // any unmasked latched event raises the pending line
    assign irq_pending = |(stat_q & ~mask_q);

    AST_MASK_ALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_pending); // R8
    AST_NO_PEND_NO_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq_pending); // R8
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] pin_in = 16'hFFFF;
    logic [15:0] pin_out, pin_oe, pin_alt;
    logic        irq_pending;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt(pin_alt),
        .irq_pending(irq_pending)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(4'd0, v); chk("R1 out", v, 16'h0);
        rd(4'd1, v); chk("R1 dir", v, 16'h0);
        rd(4'd4, v); chk("R1 mask", v, 16'hFFFF);
        rd(4'd5, v); chk("R1 trig", v, 16'h0);
        rd(4'd8, v); chk("R1 status", v, 16'h0);
        chk("R1 pending", {15'b0, irq_pending}, 16'h0);
    endtask

    task automatic t_outputs();
        logic [15:0] v;
        wr(4'd0, 16'hA5A5); wr(4'd1, 16'h0F0F); wr(4'd2, 16'h3C3C);
        chk("R2 pin_out", pin_out, 16'hA5A5);
        chk("R2 pin_oe", pin_oe, 16'h0F0F);
        chk("R2 pin_alt", pin_alt, 16'h3C3C);
        rd(4'd2, v); chk("R2 alt readback", v, 16'h3C3C);
    endtask

    task automatic t_pins();
        logic [15:0] v;
        @(negedge clk); pin_in = 16'h5AFF;
        edges(1); rd(4'd3, v); chk("R3 not yet", v, 16'hFFFF);
        edges(1); rd(4'd3, v); chk("R3 pins", v, 16'h5AFF);
        wr(4'd3, 16'h0000);
        rd(4'd3, v); chk("R9 pins write ignored", v, 16'h5AFF);
        rd(4'd12, v); chk("R9 unmapped", v, 16'h0);
        @(negedge clk); pin_in = 16'hFFFF;
        edges(3);
    endtask

    task automatic t_rise();
        logic [15:0] v;
        wr(4'd5, 16'hFFFF); wr(4'd6, 16'hFFFF); wr(4'd8, 16'h0);
        @(negedge clk); pin_in[3] = 1'b0;
        edges(4); rd(4'd8, v); chk("R4 falling ignored", v, 16'h0);
        @(negedge clk); pin_in[3] = 1'b1;
        edges(2); rd(4'd8, v); chk("R4 early", v, 16'h0);
        edges(1); rd(4'd8, v); chk("R4 rising", v, 16'h0008);
        chk("R8 masked latched no pend", {15'b0, irq_pending}, 16'h0);
        wr(4'd4, 16'hFFF7);
        chk("R8 pending", {15'b0, irq_pending}, 16'h1);
        wr(4'd4, 16'hFFFF); wr(4'd8, 16'h0);
    endtask

    task automatic t_fall();
        logic [15:0] v;
        wr(4'd6, 16'hFFDF);
        @(negedge clk); pin_in[5] = 1'b0;
        edges(3); rd(4'd8, v); chk("R5 falling", v, 16'h0020);
        wr(4'd8, 16'h0);
        @(negedge clk); pin_in[5] = 1'b1;
        edges(4); rd(4'd8, v); chk("R5 rising ignored", v, 16'h0);
    endtask

    task automatic t_level();
        logic [15:0] v;
        wr(4'd7, 16'h0100); wr(4'd5, 16'hFEFF);
        edges(1); wr(4'd8, 16'h0);
        rd(4'd8, v); chk("R6 high level re-sets", v, 16'h0100);
        @(negedge clk); pin_in[8] = 1'b0;
        edges(3); wr(4'd8, 16'h0);
        edges(1); rd(4'd8, v); chk("R6 inactive stays clear", v, 16'h0);
        wr(4'd7, 16'h0000);
        edges(1); rd(4'd8, v); chk("R6 low level", v, 16'h0100);
        wr(4'd5, 16'hFFFF); wr(4'd8, 16'h0);
        edges(1); rd(4'd8, v); chk("R6 edge mode quiet", v, 16'h0);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        wr(4'd6, 16'h0000);
        @(negedge clk); pin_in[1:0] = 2'b00;
        edges(3); rd(4'd8, v); chk("R7 two events", v, 16'h0003);
        wr(4'd8, 16'h0002);
        rd(4'd8, v); chk("R7 keep ones", v, 16'h0002);
        @(negedge clk); pin_in[2] = 1'b0;
        repeat (2) @(posedge clk);
        wr(4'd8, 16'h0);
        rd(4'd8, v); chk("R7 event beats clear", v, 16'h0004);
        wr(4'd4, 16'hFFFB);
        chk("R8 unmasked pending", {15'b0, irq_pending}, 16'h1);
        wr(4'd8, 16'h0);
        chk("R8 cleared no pend", {15'b0, irq_pending}, 16'h0);
        wr(4'd4, 16'hFFFF);
    endtask

    task automatic t_both();
        logic [15:0] v;
        wr(4'd6, 16'h0000); wr(4'd8, 16'h0);
        @(negedge clk); pin_in[10] = 1'b0;
        edges(3); rd(4'd8, v); chk("R10 first falling", v, 16'h0400);
        wr(4'd6, 16'h0400); wr(4'd8, 16'h0);
        @(negedge clk); pin_in[10] = 1'b1;
        edges(3); rd(4'd8, v); chk("R10 flipped rising", v, 16'h0400);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        edges(5);
        begin
            logic [15:0] v;
            rd(4'd8, v); chk("R1 quiet after reset", v, 16'h0);
        end
        t_outputs();
        t_pins();
        t_rise();
        t_fall();
        t_level();
        t_clear();
        t_both();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule